// File: doc/BRIEF.md
# Clear-on-read interrupt status unit

This block gathers the interrupt sources of one channel of a serial communications controller into a single 8-bit status register. Software reads the register, and the read clears it. Three of the sources are derived from FIFO and serializer conditions:

- a character arriving into a full receive FIFO;
- the receive FIFO occupancy reaching its programmed threshold;
- the transmit FIFO being empty when the last character leaves the line.

The other five arrive as single-cycle pulses: transmit underrun, timer expiry, modem status change, transmit message repeat and transmit pool ready.

A mask register gates which latched bits raise the level-sensitive interrupt request and the summary bit for the global status register. A visibility control decides what happens to a masked event:

- with visibility set, a masked event is still latched, so software can poll it;
- with visibility clear, a masked event is dropped.

The transmit-pool-ready bit is also cleared by a vector acknowledge that names this block's source code. A transmit underrun drops the transmitter enable, which stays low until software reads the status register.

Top module: `irq_status_unit`

## Requirements
- R1: After reset the status and mask registers read 0x00, irq_o and gis_sum_o are 0, and tx_en_o is 1.
- R2: A cycle with stat_rd_i high clears every status bit at the next edge, except bits whose event is accepted in that same cycle, which stay set.
- R3: A cycle with vec_ack_i high and vec_src_i equal to XPR_VEC_ID clears status bit 0 at the next edge unless a transmit-pool-ready event is accepted in that cycle. Any other vec_src_i value has no effect on the status.
- R4: An event whose mask bit is 1 is latched only when vis_i is 1. With vis_i at 0 it is dropped. Unmasked events are always latched. The mask value used is the one held before that edge.
- R5: irq_o and gis_sum_o are 1 exactly when some status bit is set and its mask bit is 0. A masked bit never drives them, even when it is visible.
- R6: Status bit 7 (receive overflow) is set when rx_char_i is high while rfifo_full_i is high.
- R7: Status bit 6 (receive pool full) is set in the cycle after the condition rfifo_level_i >= rfifo_thresh_i first becomes true, compared with the previous cycle. This happens only while int_mode_i is 1.
- R8: Status bit 5 (all sent) is set when tx_last_done_i is high while xfifo_empty_i is high.
- R9: xdu_evt_i sets status bit 4 and drives tx_en_o low from the next edge. tx_en_o returns to 1 only after a status read in which no new underrun arrives. This holds whatever the mask or the visibility.
- R10: The pulse inputs tin_evt_i, csc_evt_i, xmr_evt_i and xpr_evt_i set status bits 3, 2, 1 and 0 respectively.
- R11: mask_wr_i loads mask_wdata_i into the mask register at the next edge, and mask_o reads it back. A 1 in a mask bit means masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_char_i | input | 1 | A received character is offered to the receive FIFO |
| rfifo_full_i | input | 1 | Receive FIFO is full |
| rfifo_level_i | input | LVL_W | Receive FIFO occupancy, data plus status |
| rfifo_thresh_i | input | LVL_W | Programmed receive threshold |
| int_mode_i | input | 1 | Channel runs in interrupt mode |
| xfifo_empty_i | input | 1 | Transmit FIFO is empty |
| tx_last_done_i | input | 1 | Last character has fully left the serial output |
| xdu_evt_i | input | 1 | Transmit underrun pulse |
| tin_evt_i | input | 1 | Timer expiry pulse |
| csc_evt_i | input | 1 | Modem status change pulse |
| xmr_evt_i | input | 1 | Transmit message repeat pulse |
| xpr_evt_i | input | 1 | Transmit pool ready pulse |
| mask_wr_i | input | 1 | Write strobe for the mask register |
| mask_wdata_i | input | 8 | Mask write data |
| mask_o | output | 8 | Mask register contents |
| vis_i | input | 1 | Masked events remain visible in the status register |
| stat_rd_i | input | 1 | Status register read strobe |
| stat_rdata_o | output | 8 | Status register contents |
| vec_ack_i | input | 1 | An interrupt vector is being output |
| vec_src_i | input | SRC_W | Source code of the vector being output |
| irq_o | output | 1 | Interrupt request, active high, level |
| gis_sum_o | output | 1 | Summary bit for the global status register |
| tx_en_o | output | 1 | Enable for transmitter and transmit FIFO |

## Verification
Every event, read, acknowledge and mask write is applied in one cycle and shows on stat_rdata_o, mask_o and tx_en_o after the next rising edge. The one exception is the threshold crossing, which is compared with a registered copy of the condition but still lands one edge after the level changes. irq_o and gis_sum_o follow the registers with no further delay.

The bench drives inputs on the falling edge and advances its reference model at the rising edge. It compares all outputs at the following falling edge, so each result is checked in the cycle it is due. The directed cases cover:

- a read together with a new event;
- an acknowledge together with a new transmit-pool-ready event;
- an underrun together with a read;
- visibility toggled while events are masked.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
  localparam int unsigned NUM_SRC = 8;
  localparam int unsigned B_RFO = 7;
  localparam int unsigned B_RPF = 6;
  localparam int unsigned B_ALL = 5;
  localparam int unsigned B_XDU = 4;
  localparam int unsigned B_TIN = 3;
  localparam int unsigned B_CSC = 2;
  localparam int unsigned B_XMR = 1;
  localparam int unsigned B_XPR = 0;
  typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/irq_evt_cond.sv
module irq_evt_cond
  import irq_status_pkg::*;
#(
  parameter int unsigned LVL_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_char_i,
  input  logic             rfifo_full_i,
  input  logic [LVL_W-1:0] rfifo_level_i,
  input  logic [LVL_W-1:0] rfifo_thresh_i,
  input  logic             int_mode_i,
  input  logic             xfifo_empty_i,
  input  logic             tx_last_done_i,
  input  logic             xdu_evt_i,
  input  logic             tin_evt_i,
  input  logic             csc_evt_i,
  input  logic             xmr_evt_i,
  input  logic             xpr_evt_i,
  output src_vec_t         evt_o
);
  logic thr_hit, thr_hit_q;

  assign thr_hit = rfifo_level_i >= rfifo_thresh_i;

  // edge of the threshold condition, tracked in every mode
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) thr_hit_q <= 1'b0;
    else         thr_hit_q <= thr_hit;
  end

  always_comb begin
    evt_o        = '0;
    evt_o[B_RFO] = rx_char_i & rfifo_full_i;
    evt_o[B_RPF] = int_mode_i & thr_hit & ~thr_hit_q;
    evt_o[B_ALL] = xfifo_empty_i & tx_last_done_i;
    evt_o[B_XDU] = xdu_evt_i;
    evt_o[B_TIN] = tin_evt_i;
    evt_o[B_CSC] = csc_evt_i;
    evt_o[B_XMR] = xmr_evt_i;
    evt_o[B_XPR] = xpr_evt_i;
  end
endmodule

// File: rtl/irq_status_latch.sv
module irq_status_latch
  import irq_status_pkg::*;
#(
  parameter int unsigned SRC_W      = 4,
  parameter int unsigned XPR_VEC_ID = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  src_vec_t         evt_i,
  input  src_vec_t         mask_i,
  input  logic             vis_i,
  input  logic             stat_rd_i,
  input  logic             vec_ack_i,
  input  logic [SRC_W-1:0] vec_src_i,
  output src_vec_t         evt_acc_o,
  output src_vec_t         stat_o
);
  src_vec_t stat_q, clr;

  assign evt_acc_o = evt_i & (~mask_i | {NUM_SRC{vis_i}});

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_clr
      if (i == B_XPR) begin : g_vec
        assign clr[i] = stat_rd_i |
                        (vec_ack_i && vec_src_i == SRC_W'(XPR_VEC_ID));
      end else begin : g_rd
        assign clr[i] = stat_rd_i;
      end
    end
  endgenerate

  // set wins over clear: no event lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q & ~clr) | evt_acc_o;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/irq_tx_hold.sv
module irq_tx_hold (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic xdu_i,
  input  logic stat_rd_i,
  output logic tx_en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        tx_en_o <= 1'b1;
    else if (xdu_i)     tx_en_o <= 1'b0;
    else if (stat_rd_i) tx_en_o <= 1'b1;
  end
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_status_pkg::*;
#(
  parameter int unsigned LVL_W      = 6,
  parameter int unsigned SRC_W      = 4,
  parameter int unsigned XPR_VEC_ID = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_char_i,
  input  logic             rfifo_full_i,
  input  logic [LVL_W-1:0] rfifo_level_i,
  input  logic [LVL_W-1:0] rfifo_thresh_i,
  input  logic             int_mode_i,
  input  logic             xfifo_empty_i,
  input  logic             tx_last_done_i,
  input  logic             xdu_evt_i,
  input  logic             tin_evt_i,
  input  logic             csc_evt_i,
  input  logic             xmr_evt_i,
  input  logic             xpr_evt_i,
  input  logic             mask_wr_i,
  input  logic [7:0]       mask_wdata_i,
  output logic [7:0]       mask_o,
  input  logic             vis_i,
  input  logic             stat_rd_i,
  output logic [7:0]       stat_rdata_o,
  input  logic             vec_ack_i,
  input  logic [SRC_W-1:0] vec_src_i,
  output logic             irq_o,
  output logic             gis_sum_o,
  output logic             tx_en_o
);
  src_vec_t evt_raw, evt_acc, stat, mask_q;

  irq_evt_cond #(.LVL_W(LVL_W)) u_cond (
    .clk_i, .rst_ni, .rx_char_i, .rfifo_full_i, .rfifo_level_i,
    .rfifo_thresh_i, .int_mode_i, .xfifo_empty_i, .tx_last_done_i,
    .xdu_evt_i, .tin_evt_i, .csc_evt_i, .xmr_evt_i, .xpr_evt_i,
    .evt_o(evt_raw)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= '0;
    else if (mask_wr_i) mask_q <= mask_wdata_i;
  end

  irq_status_latch #(.SRC_W(SRC_W), .XPR_VEC_ID(XPR_VEC_ID)) u_latch (
    .clk_i, .rst_ni, .evt_i(evt_raw), .mask_i(mask_q), .vis_i,
    .stat_rd_i, .vec_ack_i, .vec_src_i, .evt_acc_o(evt_acc), .stat_o(stat)
  );

  irq_tx_hold u_hold (
    .clk_i, .rst_ni, .xdu_i(xdu_evt_i), .stat_rd_i, .tx_en_o
  );

  assign mask_o       = mask_q;
  assign stat_rdata_o = stat;
  assign irq_o        = |(stat & ~mask_q);
  assign gis_sum_o    = irq_o;
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk #(
  parameter int unsigned SRC_W      = 4,
  parameter int unsigned XPR_VEC_ID = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rx_char_i,
  input logic             rfifo_full_i,
  input logic             xdu_evt_i,
  input logic             xpr_evt_i,
  input logic             vis_i,
  input logic             stat_rd_i,
  input logic             vec_ack_i,
  input logic [SRC_W-1:0] vec_src_i,
  input logic [7:0]       mask_o,
  input logic [7:0]       stat_rdata_o,
  input logic [7:0]       evt_acc,
  input logic             irq_o,
  input logic             gis_sum_o,
  input logic             tx_en_o
);
  assert_read_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd_i |=> (stat_rdata_o & ~$past(evt_acc)) == 8'h00);

  assert_vec_ack_xpr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_ack_i && vec_src_i == SRC_W'(XPR_VEC_ID) && !xpr_evt_i) |=> !stat_rdata_o[0]);

  assert_irq_needs_bit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (stat_rdata_o != 8'h00));

  assert_gis_matches_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gis_sum_o == irq_o);

  assert_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_char_i && rfifo_full_i && (vis_i || !mask_o[7])) |=> stat_rdata_o[7]);

  assert_underrun_halt_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xdu_evt_i |=> !tx_en_o);

  assert_resume_on_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_en_o) |-> $past(stat_rd_i));
endmodule

bind irq_status_unit irq_status_chk #(.SRC_W(SRC_W), .XPR_VEC_ID(XPR_VEC_ID)) u_chk (
  .clk_i, .rst_ni, .rx_char_i, .rfifo_full_i, .xdu_evt_i, .xpr_evt_i, .vis_i,
  .stat_rd_i, .vec_ack_i, .vec_src_i, .mask_o, .stat_rdata_o, .evt_acc,
  .irq_o, .gis_sum_o, .tx_en_o
);

// File: tb/tb_irq_status_unit.sv
module tb_irq_status_unit;
  localparam int LVL_W = 6;
  localparam int SRC_W = 4;
  localparam int XPR_ID = 2;

  logic clk = 0, rst_n = 0;
  logic rx_char, rf_full, int_mode, xf_empty, tx_done;
  logic xdu, tin, csc, xmr, xpr, mask_wr, vis, rd, vack;
  logic [LVL_W-1:0] lvl, thr;
  logic [7:0] mask_wd, mask_o, stat_o;
  logic [SRC_W-1:0] vsrc;
  logic irq, gis, tx_en;

  int n_chk = 0, n_fail = 0;
  logic [7:0] e_stat, e_mask;
  logic e_txen, e_thr_q;

  always #2.5 clk = ~clk;

  irq_status_unit #(.LVL_W(LVL_W), .SRC_W(SRC_W), .XPR_VEC_ID(XPR_ID)) dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_char_i(rx_char), .rfifo_full_i(rf_full),
    .rfifo_level_i(lvl), .rfifo_thresh_i(thr), .int_mode_i(int_mode),
    .xfifo_empty_i(xf_empty), .tx_last_done_i(tx_done), .xdu_evt_i(xdu),
    .tin_evt_i(tin), .csc_evt_i(csc), .xmr_evt_i(xmr), .xpr_evt_i(xpr),
    .mask_wr_i(mask_wr), .mask_wdata_i(mask_wd), .mask_o(mask_o), .vis_i(vis),
    .stat_rd_i(rd), .stat_rdata_o(stat_o), .vec_ack_i(vack), .vec_src_i(vsrc),
    .irq_o(irq), .gis_sum_o(gis), .tx_en_o(tx_en)
  );

  task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] raw_events();
    logic [7:0] ev;
    logic hit;
    hit   = lvl >= thr;
    ev    = '0;
    ev[7] = rx_char & rf_full;
    ev[6] = int_mode & hit & ~e_thr_q;
    ev[5] = xf_empty & tx_done;
    ev[4] = xdu; ev[3] = tin; ev[2] = csc; ev[1] = xmr; ev[0] = xpr;
    return ev;
  endfunction

  function automatic logic exp_irq(logic [7:0] s, logic [7:0] m);
    return |(s & ~m);
  endfunction

  task automatic idle();
    rx_char = 0; tin = 0; csc = 0; xmr = 0; xpr = 0; xdu = 0; tx_done = 0;
    mask_wr = 0; rd = 0; vack = 0;
  endtask

  task automatic step(string tag);
    logic [7:0] acc, clr;
    acc = raw_events() & (~e_mask | {8{vis}});
    clr = {8{rd}};
    if (vack && vsrc == SRC_W'(XPR_ID)) clr[0] = 1'b1;
    @(posedge clk);
    e_stat  = (e_stat & ~clr) | acc;
    e_thr_q = lvl >= thr;
    if (xdu)     e_txen = 1'b0;
    else if (rd) e_txen = 1'b1;
    if (mask_wr) e_mask = mask_wd;
    @(negedge clk);
    check(tag, "status", stat_o, e_stat);
    check("R11", "mask", mask_o, e_mask);
    check("R5", "irq", {7'd0, irq}, {7'd0, exp_irq(e_stat, e_mask)});
    check("R5", "gis", {7'd0, gis}, {7'd0, exp_irq(e_stat, e_mask)});
    check("R9", "tx_en", {7'd0, tx_en}, {7'd0, e_txen});
    idle();
  endtask

  initial begin
    #1000000;
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    idle();
    rf_full = 0; int_mode = 1; xf_empty = 0; vis = 0; mask_wd = 0; vsrc = 0;
    lvl = 0; thr = 8;
    e_stat = 0; e_mask = 0; e_txen = 1; e_thr_q = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1", "reset status", stat_o, 8'h00);
    check("R1", "reset mask", mask_o, 8'h00);
    check("R1", "reset irq/tx_en", {6'd0, irq, tx_en}, 8'h01);

    // R10 pulse sources land on bits 3..0
    tin = 1; step("R10"); check("R10", "tin bit3", stat_o, 8'h08);
    csc = 1; xmr = 1; step("R10");
    xpr = 1; step("R10"); check("R10", "bits 3..0", stat_o, 8'h0f);
    // R2 read with simultaneous event keeps that event
    rd = 1; csc = 1; step("R2"); check("R2", "read keeps new", stat_o, 8'h04);
    rd = 1; step("R2"); check("R2", "read clears", stat_o, 8'h00);
    // R6 overflow
    rx_char = 1; step("R6"); check("R6", "no full", stat_o, 8'h00);
    rf_full = 1; rx_char = 1; step("R6"); check("R6", "overflow", stat_o, 8'h80);
    rf_full = 0; rd = 1; step("R2");
    // R8 all sent
    tx_done = 1; step("R8"); check("R8", "not empty", stat_o, 8'h00);
    xf_empty = 1; tx_done = 1; step("R8"); check("R8", "all sent", stat_o, 8'h20);
    xf_empty = 0; rd = 1; step("R2");
    // R7 threshold crossing
    lvl = 8; step("R7"); check("R7", "crossing", stat_o, 8'h40);
    rd = 1; step("R7"); lvl = 9; step("R7"); check("R7", "stay above no retrigger", stat_o, 8'h00);
    lvl = 2; step("R7"); int_mode = 0; lvl = 8; step("R7");
    check("R7", "no interrupt mode", stat_o, 8'h00);
    lvl = 0; int_mode = 1; step("R7");
    // R3 vector acknowledge
    xpr = 1; tin = 1; step("R3");
    vack = 1; vsrc = 4'd5; step("R3"); check("R3", "other id", stat_o, 8'h09);
    vack = 1; vsrc = 4'(XPR_ID); step("R3"); check("R3", "xpr id", stat_o, 8'h08);
    xpr = 1; step("R3"); vack = 1; xpr = 1; step("R3");
    check("R3", "ack with new xpr", stat_o, 8'h09);
    rd = 1; step("R2");
    // R4 visibility
    mask_wr = 1; mask_wd = 8'hff; step("R11");
    tin = 1; step("R4"); check("R4", "masked hidden", stat_o, 8'h00);
    vis = 1; tin = 1; step("R4"); check("R4", "masked visible", stat_o, 8'h08);
    check("R5", "masked no irq", {7'd0, irq}, 8'h00);
    mask_wr = 1; mask_wd = 8'h00; step("R5"); check("R5", "unmask irq", {7'd0, irq}, 8'h01);
    rd = 1; vis = 0; step("R2");
    // R9 underrun hold, masked and with read in same cycle
    mask_wr = 1; mask_wd = 8'h10; step("R11");
    xdu = 1; step("R9"); check("R9", "halt", {7'd0, tx_en}, 8'h00);
    check("R9", "masked hidden", stat_o, 8'h00);
    step("R9"); rd = 1; xdu = 1; step("R9"); check("R9", "read+xdu stays low", {7'd0, tx_en}, 8'h00);
    rd = 1; step("R9"); check("R9", "resume", {7'd0, tx_en}, 8'h01);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      rx_char = ($urandom % 4) == 0; rf_full = ($urandom % 3) == 0;
      tx_done = ($urandom % 6) == 0; xf_empty = ($urandom % 2) == 0;
      xdu = ($urandom % 20) == 0; tin = ($urandom % 10) == 0;
      csc = ($urandom % 10) == 0; xmr = ($urandom % 10) == 0;
      xpr = ($urandom % 8) == 0; rd = ($urandom % 6) == 0;
      vack = ($urandom % 6) == 0; vsrc = SRC_W'($urandom % 4);
      mask_wr = ($urandom % 16) == 0; mask_wd = 8'($urandom);
      if (($urandom % 32) == 0) vis = ~vis;
      if (($urandom % 32) == 0) int_mode = ~int_mode;
      if (($urandom % 3) == 0) lvl = LVL_W'($urandom % 16);
      if (($urandom % 64) == 0) thr = LVL_W'($urandom % 16);
      step("R4");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule